// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a 32-lane SIMD thread are allowed to commit results while the thread runs through nested, divergent if/else regions. Every lane executes every instruction. The active mask produced here only gates each lane's write-back. The mask changes in three ways:

- At a divergent branch, the current mask is saved on a hardware stack. The new mask keeps only the active lanes whose predicate is set.
- On entry to the else path, the active lanes become the saved lanes whose predicate is clear.
- At the reconvergence point, the saved mask is popped and becomes active again.

The caller supplies a per-lane predicate bit with every command. The same predicate that drove the branch must be presented again with the else command. Stack depth is a parameter. A push into a full stack raises a one-cycle overflow pulse. A pop or else on an empty stack raises a one-cycle underflow pulse. In both error cases the state is left untouched.

Top module: `simt_mask_stack`

## Requirements
- R1: While reset is held and in the first cycle after it, the active mask is all ones, the stack is empty and both error flags are low.
- R2: Command code 2'b00 (idle) leaves the mask and the stack unchanged, whatever the predicate.
- R3: Command code 2'b01 (branch) saves the current mask on the stack. In the next cycle the active mask equals the old mask AND the predicate.
- R4: Command code 2'b10 (else) sets the active mask to the saved top entry AND the inverted predicate. The stack contents and depth do not change.
- R5: Command code 2'b11 (reconverge) makes the saved top entry the active mask and removes it from the stack.
- R6: Branches nest up to DEPTH levels. Entries come back in last-in, first-out order.
- R7: A branch command while DEPTH entries are held sets the overflow flag for exactly one cycle. The mask and the stack stay unchanged.
- R8: A reconverge or else command on an empty stack sets the underflow flag for exactly one cycle and leaves the mask unchanged. Overflow and underflow are never high together.
- R9: A branch whose predicate is uniform across the active lanes still pushes. This holds for an all-zero result too, so each branch is matched by exactly one reconverge.
- R10: The predicate has no effect during reconverge commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | 00 idle, 01 branch, 10 else, 11 reconverge |
| pred_i | input | LANES | Per-lane predicate from the compare |
| active_mask_o | output | LANES | Lanes allowed to commit results |
| overflow_o | output | 1 | One-cycle pulse: branch refused, stack full |
| underflow_o | output | 1 | One-cycle pulse: else/reconverge on empty stack |

## Verification
The assertions take for granted that `cmd_i` and `pred_i` hold known values that are stable around each rising edge. They also assume that the caller presents a new command only after the previous one has been registered. The properties compare the registered mask against its value one or two cycles earlier, so they rely on commands being sampled exactly once per edge. The stimulus drives every input on the falling edge and samples outputs one nanosecond after the rising edge. It re-presents the branch predicate with each else command and returns the stack to empty at the end of each scenario.

// File: rtl/dms_pkg.sv
`timescale 1ns/1ps
package dms_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_PUSH = 2'b01,
        CMD_ELSE = 2'b10,
        CMD_POP  = 2'b11
    } dms_cmd_e;

    // How the next active mask is formed
    typedef enum logic [1:0] {
        SEL_HOLD,
        SEL_AND_PRED,
        SEL_TOP_INV,
        SEL_TOP
    } dms_sel_e;

endpackage

// File: rtl/dms_ctrl.sv
`timescale 1ns/1ps
module dms_ctrl #(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input  dms_pkg::dms_cmd_e cmd_i,
    input  logic [LW-1:0]     level_i,
    output logic [LW-1:0]     level_o,
    output dms_pkg::dms_sel_e sel_o,
    output logic              wr_en_o,
    output logic              ovf_o,
    output logic              unf_o
);
    import dms_pkg::*;

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic full_w;
    logic empty_w;

    assign full_w  = (level_i == FULL_LVL);
    assign empty_w = (level_i == '0);

    always_comb begin
        level_o = level_i;
        sel_o   = SEL_HOLD;
        wr_en_o = 1'b0;
        ovf_o   = 1'b0;
        unf_o   = 1'b0;
        unique case (cmd_i)
            CMD_PUSH: begin
                if (full_w) begin
                    ovf_o = 1'b1;
                end else begin
                    wr_en_o = 1'b1;
                    level_o = level_i + 1'b1;
                    sel_o   = SEL_AND_PRED;
                end
            end
            CMD_ELSE: begin
                if (empty_w) unf_o = 1'b1;
                else         sel_o = SEL_TOP_INV;
            end
            CMD_POP: begin
                if (empty_w) begin
                    unf_o = 1'b1;
                end else begin
                    level_o = level_i - 1'b1;
                    sel_o   = SEL_TOP;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dms_store.sv
`timescale 1ns/1ps
module dms_store #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IW-1:0]    wr_idx_i,
    input  logic [LANES-1:0] wr_data_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [LANES-1:0] rd_data_o
);
    logic [LANES-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [LANES-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en_i && (wr_idx_i == IW'(g))) slot_d = wr_data_i;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[g] <= '1;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];

    // R6: a saved mask lands in the addressed slot
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> slot_q[$past(wr_idx_i)] == $past(wr_data_i));

endmodule

// File: rtl/simt_mask_stack.sv
`timescale 1ns/1ps
module simt_mask_stack #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_i,
    input  logic [LANES-1:0] pred_i,
    output logic [LANES-1:0] active_mask_o,
    output logic             overflow_o,
    output logic             underflow_o
);
    import dms_pkg::*;

    localparam int LW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [LW-1:0]    level;
        logic             ovf;
        logic             unf;
    } state_t;

    state_t state_d, state_q;

    dms_cmd_e         cmd_w;
    dms_sel_e         sel_w;
    logic [LW-1:0]    level_w;
    logic             wr_en_w;
    logic             ovf_w;
    logic             unf_w;
    logic [LANES-1:0] top_w;
    logic [IW-1:0]    wr_idx_w;
    logic [IW-1:0]    rd_idx_w;

    assign cmd_w    = dms_cmd_e'(cmd_i);
    assign wr_idx_w = IW'(state_q.level);
    assign rd_idx_w = IW'(state_q.level - 1'b1);

    dms_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_ctrl (
        .cmd_i   (cmd_w),
        .level_i (state_q.level),
        .level_o (level_w),
        .sel_o   (sel_w),
        .wr_en_o (wr_en_w),
        .ovf_o   (ovf_w),
        .unf_o   (unf_w)
    );

    dms_store #(.LANES(LANES), .DEPTH(DEPTH), .IW(IW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_w),
        .wr_idx_i  (wr_idx_w),
        .wr_data_i (state_q.mask),
        .rd_idx_i  (rd_idx_w),
        .rd_data_o (top_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.level = level_w;
        state_d.ovf   = ovf_w;
        state_d.unf   = unf_w;
        unique case (sel_w)
            SEL_AND_PRED: state_d.mask = state_q.mask & pred_i;
            SEL_TOP_INV:  state_d.mask = top_w & ~pred_i;
            SEL_TOP:      state_d.mask = top_w;
            default:      state_d.mask = state_q.mask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.mask  <= '1;
            state_q.level <= '0;
            state_q.ovf   <= 1'b0;
            state_q.unf   <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active_mask_o = state_q.mask;
    assign overflow_o    = state_q.ovf;
    assign underflow_o   = state_q.unf;

    logic full_q;
    logic empty_q;
    assign full_q  = (state_q.level == FULL_LVL);
    assign empty_q = (state_q.level == '0);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'b00) |=> $stable(active_mask_o) && $stable(state_q.level));

    p_push_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'b01 && !full_q) |=> active_mask_o == $past(active_mask_o & pred_i));

    p_else_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'b10 && !empty_q) |=>
            active_mask_o == $past(top_w & ~pred_i) && $stable(state_q.level));

    p_pop_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'b01 && !full_q) ##1 (cmd_i == 2'b11) |=>
            active_mask_o == $past(active_mask_o, 2));

    p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.level <= FULL_LVL);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'b01 && full_q) |=>
            overflow_o && $stable(active_mask_o) && $stable(state_q.level));

    p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == 2'b11 || cmd_i == 2'b10) && empty_q) |=>
            underflow_o && $stable(active_mask_o));

    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({overflow_o, underflow_o}));

endmodule

// File: tb/simt_mask_stack_bench.sv
`timescale 1ns/1ps
module simt_mask_stack_bench;
    localparam int LANES = 32;
    localparam int DEPTH = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       cmd;
    logic [LANES-1:0] pred;
    logic [LANES-1:0] mask;
    logic             ovf;
    logic             unf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_simt_mask_stack (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd),
        .pred_i        (pred),
        .active_mask_o (mask),
        .overflow_o    (ovf),
        .underflow_o   (unf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] c, input logic [31:0] p);
        @(negedge clk);
        cmd  = c;
        pred = p;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_r1();
        chk("R1 mask after reset", mask, 32'hFFFF_FFFF);
        chk("R1 overflow low", {31'd0, ovf}, 32'd0);
        chk("R1 underflow low", {31'd0, unf}, 32'd0);
    endtask

    task automatic t_idle_r2();
        step(2'b00, 32'h0000_0000);
        chk("R2 idle keeps mask", mask, 32'hFFFF_FFFF);
        step(2'b00, 32'h1234_5678);
        chk("R2 idle ignores pred", mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_if_else_r3();
        step(2'b01, 32'h0000_FFFF);
        chk("R3 push ands pred", mask, 32'h0000_FFFF);
        step(2'b10, 32'h0000_FFFF);
        chk("R4 else inverts", mask, 32'hFFFF_0000);
        step(2'b10, 32'h0000_FFFF);
        chk("R4 else repeat same depth", mask, 32'hFFFF_0000);
        step(2'b11, 32'h0F0F_0F0F);
        chk("R5 R10 pop restores", mask, 32'hFFFF_FFFF);
        chk("R5 no underflow", {31'd0, unf}, 32'd0);
    endtask

    task automatic t_nest_r6();
        step(2'b01, 32'h00FF_00FF);
        chk("R6 outer push", mask, 32'h00FF_00FF);
        step(2'b01, 32'h0F0F_0F0F);
        chk("R6 inner push", mask, 32'h000F_000F);
        step(2'b10, 32'h0F0F_0F0F);
        chk("R6 inner else", mask, 32'h00F0_00F0);
        step(2'b11, 32'hFFFF_FFFF);
        chk("R6 inner pop", mask, 32'h00FF_00FF);
        step(2'b10, 32'h00FF_00FF);
        chk("R6 outer else", mask, 32'hFF00_FF00);
        step(2'b11, 32'h0000_0000);
        chk("R6 outer pop", mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_overflow_r7();
        for (int i = 0; i < DEPTH; i++) begin
            step(2'b01, ~(32'd1 << i));
            chk("R6 fill push", mask, ~((32'd1 << (i + 1)) - 32'd1));
        end
        step(2'b01, 32'h0000_0000);
        chk("R7 overflow raised", {31'd0, ovf}, 32'd1);
        chk("R7 mask unchanged", mask, ~((32'd1 << DEPTH) - 32'd1));
        step(2'b00, 32'h0000_0000);
        chk("R7 overflow one cycle", {31'd0, ovf}, 32'd0);
        for (int k = DEPTH - 1; k >= 0; k--) begin
            step(2'b11, 32'h0000_0000);
            chk("R7 R6 drain pop", mask, ~((32'd1 << k) - 32'd1));
        end
    endtask

    task automatic t_underflow_r8();
        step(2'b11, 32'h0000_0000);
        chk("R8 pop empty underflow", {31'd0, unf}, 32'd1);
        chk("R8 pop empty mask", mask, 32'hFFFF_FFFF);
        chk("R8 no overflow", {31'd0, ovf}, 32'd0);
        step(2'b00, 32'h0000_0000);
        chk("R8 underflow one cycle", {31'd0, unf}, 32'd0);
        step(2'b10, 32'hFFFF_0000);
        chk("R8 else empty underflow", {31'd0, unf}, 32'd1);
        chk("R8 else empty mask", mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_uniform_r9();
        step(2'b01, 32'h0000_0000);
        chk("R9 uniform false push", mask, 32'h0000_0000);
        step(2'b01, 32'hFFFF_FFFF);
        chk("R9 nested all-off push", mask, 32'h0000_0000);
        step(2'b11, 32'hFFFF_FFFF);
        chk("R9 first pop", mask, 32'h0000_0000);
        chk("R9 no underflow", {31'd0, unf}, 32'd0);
        step(2'b11, 32'hFFFF_FFFF);
        chk("R9 second pop", mask, 32'hFFFF_FFFF);
        step(2'b11, 32'h0000_0000);
        chk("R9 stack now empty", {31'd0, unf}, 32'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        cmd   = 2'b00;
        pred  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset_r1();
        t_idle_r2();
        t_if_else_r3();
        t_nest_r6();
        t_overflow_r7();
        t_underflow_r8();
        t_uniform_r9();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule